// File: doc/BRIEF.md
# Serial Output Port for a Sigma-Delta Converter

This block is the digital back end of a sigma-delta converter that runs in serial mode. It takes conversion words from an internal source and holds the newest one. It raises a data-ready flag for that word. When a frame is requested, it shifts the word out most significant bit first on a serial clock. The serial clock is the system clock divided by two and appears on a pin. The serial data pin has a separate output-enable, so the chip pads can place it in high impedance.

Serial mode is chosen by the levels of three active-low strobes, which are sampled out of reset. If all three stay low for two clock edges, the port enters serial mode. If any of them is high, the port stays quiet until the next reset. The port also handles three control inputs. A synchronization pulse or a calibration pulse starts a settling window. During that window data-ready stays low and incoming words are dropped. A standby level blocks all new data-ready events.

Top module: `ser_out_port`

## Requirements
- R1: With `cs_ni`, `rd_ni` and `wr_ni` all low from reset release, `ser_mode_o` is low after the first rising clock edge and high after the second.
- R2: If any strobe is high during the entry check, the port stays out of serial mode until reset. In that state `drdy_o`, `sclk_o` and `sdata_oe_o` stay low, even when words arrive or `frame_ni` is low.
- R3: If any strobe goes high in serial mode, `ser_mode_o` drops at the next edge and `sclk_o` is low one edge later. Serial mode does not return until reset, even if the strobe is lowered again.
- R4: In serial mode `sclk_o` toggles on every clock edge, so it runs at half the clock rate.
- R5: A word accepted on `word_vld_i` sets `drdy_o` at that edge. `drdy_o` stays high until a frame starts. A later word accepted before the frame replaces the earlier one.
- R6: A frame carries the 16 bits of the word, bit 15 first. `sdata_o` changes only at the edge where `sclk_o` rises, so it is stable when `sclk_o` falls.
- R7: `sdata_oe_o` is high exactly when the port is in serial mode and `frame_ni` is low.
- R8: A frame starts only at an `sclk_o` rising edge where `frame_ni` is low and `drdy_o` is high. `drdy_o` is low from that edge on.
- R9: A word accepted while a frame is being shifted is held. `drdy_o` stays low until the frame's 16 bits are done. At the end of the frame the held word becomes current and `drdy_o` rises.
- R10: A rising edge on `sync_ni` clears `drdy_o` and drops any held word. Words offered during the next SYNC_CYC edges are discarded. The first word after that window sets `drdy_o`.
- R11: A rising edge on `cal_i` acts like R10, but the window lasts CAL_CYC edges.
- R12: While `stby_i` is high, offered words are discarded and `drdy_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select strobe, must be low for serial mode |
| rd_ni | input | 1 | Read strobe, must be low for serial mode |
| wr_ni | input | 1 | Write strobe, must be low for serial mode |
| word_i | input | WORD_W | Conversion word from the internal source |
| word_vld_i | input | 1 | Marks `word_i` as a new word this cycle |
| frame_ni | input | 1 | Frame request, active low |
| sync_ni | input | 1 | Synchronization input, acts on its rising edge |
| cal_i | input | 1 | Calibration input, acts on its rising edge |
| stby_i | input | 1 | Standby level |
| ser_mode_o | output | 1 | Serial mode active |
| drdy_o | output | 1 | A new word is ready to be read |
| sclk_o | output | 1 | Serial clock, half the system clock rate |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Output-enable for `sdata_o` |

## Verification
Words are shifted out for two sets of patterns. The first set is a walking one across all 16 positions, which shows bit-order or off-by-one shift faults. The second set is an arithmetic sequence with dense mixed bits, which shows stuck or swapped bits. A sweep over all eight strobe combinations at reset separates the one entry case from the seven lock-out cases. A word injected mid-frame shows whether it is held or corrupts the frame in flight. Sync, calibration and standby are each tried with one word inside the blocked period and one after it. Reading the next frame then shows which of the two words survived.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;
  typedef enum logic [1:0] {
    MODE_CHECK  = 2'd0,
    MODE_SERIAL = 2'd1,
    MODE_IDLE   = 2'd2
  } port_mode_e;
endpackage

// File: rtl/ser_mode_ctl.sv
module ser_mode_ctl
  import ser_out_pkg::*;
#(
  parameter int ENTRY_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_low_i,
  output logic ser_mode_o
);
  localparam int EW = $clog2(ENTRY_CYC) + 1;

  port_mode_e    st_q;
  logic [EW-1:0] ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MODE_CHECK;
      ent_q <= '0;
    end else begin
      case (st_q)
        MODE_CHECK: begin
          if (!strb_low_i)                       st_q  <= MODE_IDLE;
          else if (ent_q == EW'(ENTRY_CYC - 1))  st_q  <= MODE_SERIAL;
          else                                   ent_q <= ent_q + EW'(1);
        end
        MODE_SERIAL: if (!strb_low_i) st_q <= MODE_IDLE;
        default:     st_q <= st_q; // locked until reset
      endcase
    end
  end

  assign ser_mode_o = (st_q == MODE_SERIAL);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              frame_ni,
  input  logic              drdy_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              frame_start_o,
  output logic              frame_done_o,
  output logic              active_o
);
  localparam int BIT_W = $clog2(WORD_W);

  logic              sclk_q, active_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;
  logic              sclk_rise;

  assign sclk_rise     = ser_i & ~sclk_q;
  assign frame_start_o = sclk_rise & ~active_q & ~frame_ni & drdy_i;
  assign frame_done_o  = sclk_rise & active_q & (bit_q == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (!ser_i) begin
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
      bit_q    <= '0;
    end else begin
      sclk_q <= ~sclk_q;
      if (frame_start_o) begin
        sh_q     <= word_i;
        bit_q    <= '0;
        active_q <= 1'b1;
      end else if (frame_done_o) begin
        active_q <= 1'b0;
        bit_q    <= '0;
      end else if (sclk_rise && active_q) begin
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign sdata_o  = sh_q[WORD_W-1];
  assign active_o = active_q;
endmodule

// File: rtl/ser_word_buf.sv
module ser_word_buf #(
  parameter int WORD_W   = 16,
  parameter int SYNC_CYC = 6,
  parameter int CAL_CYC  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              sync_ni,
  input  logic              cal_i,
  input  logic              stby_i,
  input  logic              frame_start_i,
  input  logic              frame_done_i,
  input  logic              active_i,
  output logic              drdy_o,
  output logic [WORD_W-1:0] out_word_o,
  output logic              busy_o
);
  localparam int MAX_CYC = (CAL_CYC > SYNC_CYC) ? CAL_CYC : SYNC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              sync_q, cal_q, drdy_q, pend_v_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] out_q, pend_q;
  logic              sync_start, cal_start, start_any, en, take, to_pend, to_out, idle_next;

  assign sync_start = ser_i & sync_ni & ~sync_q;
  assign cal_start  = ser_i & cal_i & ~cal_q;
  assign start_any  = sync_start | cal_start;
  assign busy_o     = (cnt_q != '0);
  assign en         = ser_i & ~stby_i & ~busy_o & ~start_any;
  assign take       = en & word_vld_i;
  assign to_pend    = take & ((active_i & ~frame_done_i) | frame_start_i);
  assign to_out     = take & ~to_pend;
  assign idle_next  = ~active_i | frame_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b1;
      cal_q  <= 1'b0;
    end else begin
      sync_q <= sync_ni;
      cal_q  <= cal_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drdy_q   <= 1'b0;
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
      out_q    <= '0;
      pend_q   <= '0;
    end else if (!ser_i) begin
      drdy_q   <= 1'b0;
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_any) begin
      drdy_q   <= 1'b0;
      pend_v_q <= 1'b0;
      cnt_q    <= cal_start ? CNT_W'(CAL_CYC) : CNT_W'(SYNC_CYC);
    end else begin
      if (busy_o) cnt_q <= cnt_q - CNT_W'(1);
      if (frame_start_i) drdy_q <= 1'b0;
      if (to_out) begin
        out_q    <= word_i;
        drdy_q   <= 1'b1;
        pend_v_q <= 1'b0;
      end else if (to_pend) begin
        pend_q   <= word_i;
        pend_v_q <= 1'b1;
      end else if (pend_v_q && en && idle_next && !frame_start_i) begin
        out_q    <= pend_q;
        drdy_q   <= 1'b1;
        pend_v_q <= 1'b0;
      end
    end
  end

  assign drdy_o     = drdy_q;
  assign out_word_o = out_q;
endmodule

// File: rtl/ser_out_port.sv
module ser_out_port #(
  parameter int WORD_W    = 16,
  parameter int ENTRY_CYC = 2,
  parameter int SYNC_CYC  = 6,
  parameter int CAL_CYC   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              frame_ni,
  input  logic              sync_ni,
  input  logic              cal_i,
  input  logic              stby_i,
  output logic              ser_mode_o,
  output logic              drdy_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  logic              strb_low, ser, drdy, busy;
  logic              frame_start, frame_done, active;
  logic [WORD_W-1:0] out_word;

  assign strb_low = ~cs_ni & ~rd_ni & ~wr_ni;

  ser_mode_ctl #(.ENTRY_CYC(ENTRY_CYC)) i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strb_low_i (strb_low),
    .ser_mode_o (ser)
  );

  ser_word_buf #(.WORD_W(WORD_W), .SYNC_CYC(SYNC_CYC), .CAL_CYC(CAL_CYC)) i_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ser_i         (ser),
    .word_i        (word_i),
    .word_vld_i    (word_vld_i),
    .sync_ni       (sync_ni),
    .cal_i         (cal_i),
    .stby_i        (stby_i),
    .frame_start_i (frame_start),
    .frame_done_i  (frame_done),
    .active_i      (active),
    .drdy_o        (drdy),
    .out_word_o    (out_word),
    .busy_o        (busy)
  );

  ser_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ser_i         (ser),
    .frame_ni      (frame_ni),
    .drdy_i        (drdy),
    .word_i        (out_word),
    .sclk_o        (sclk_o),
    .sdata_o       (sdata_o),
    .frame_start_o (frame_start),
    .frame_done_o  (frame_done),
    .active_o      (active)
  );

  assign ser_mode_o = ser;
  assign drdy_o     = drdy;
  assign sdata_oe_o = ser & ~frame_ni;
endmodule

// File: rtl/ser_out_port_chk.sv
module ser_out_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic rd_ni,
  input logic wr_ni,
  input logic stby_i,
  input logic ser_mode_o,
  input logic drdy_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic busy
);
  logic strb_low;
  assign strb_low = ~cs_ni & ~rd_ni & ~wr_ni;

  AST_ENTRY_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_mode_o) |-> $past(strb_low)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_mode_o && !$past(ser_mode_o)) |-> !drdy_o); // R2
  AST_STRB_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode_o && !strb_low) |=> !ser_mode_o); // R3
  AST_SCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode_o && $past(ser_mode_o)) |-> (sclk_o != $past(sclk_o))); // R4
  AST_DATA_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdata_o)); // R6
  AST_BUSY_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |-> !$past(busy)); // R10
  AST_STBY_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |-> !$past(stby_i)); // R12
endmodule

bind ser_out_port ser_out_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .rd_ni      (rd_ni),
  .wr_ni      (wr_ni),
  .stby_i     (stby_i),
  .ser_mode_o (ser_mode_o),
  .drdy_o     (drdy_o),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .busy       (busy)
);

// File: tb/test_ser_out_port.sv
`timescale 1ns/1ps
module test_ser_out_port;
  localparam int W    = 16;
  localparam int SYNC = 6;
  localparam int CAL  = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b0, rd_ni = 1'b0, wr_ni = 1'b0;
  logic [W-1:0] word_i = '0;
  logic word_vld_i = 1'b0, frame_ni = 1'b1, sync_ni = 1'b1, cal_i = 1'b0, stby_i = 1'b0;
  logic ser_mode_o, drdy_o, sclk_o, sdata_o, sdata_oe_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_out_port #(.WORD_W(W), .ENTRY_CYC(2), .SYNC_CYC(SYNC), .CAL_CYC(CAL)) i_ser_out_port (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .word_i(word_i), .word_vld_i(word_vld_i), .frame_ni(frame_ni), .sync_ni(sync_ni),
    .cal_i(cal_i), .stby_i(stby_i), .ser_mode_o(ser_mode_o), .drdy_o(drdy_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic c, input logic r, input logic w);
    @(negedge clk);
    rst_ni = 1'b0; cs_ni = c; rd_ni = r; wr_ni = w;
    frame_ni = 1'b1; sync_ni = 1'b1; cal_i = 1'b0; stby_i = 1'b0; word_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk); word_i = w; word_vld_i = 1'b1;
    @(negedge clk); word_vld_i = 1'b0;
  endtask

  // Shift one frame; optionally inject a word after bit inj_at (-1 = none).
  task automatic read_frame(input int inj_at, input logic [W-1:0] inj_w,
                            output logic [W-1:0] got, output logic drdy_first,
                            output logic oe_ok, output logic drdy_seen);
    got = '0; oe_ok = 1'b1; drdy_seen = 1'b0; drdy_first = 1'b0;
    frame_ni = 1'b0;
    for (int b = 0; b < W; b++) begin
      @(negedge clk); word_vld_i = 1'b0;
      while (!sclk_o) begin @(negedge clk); word_vld_i = 1'b0; end
      got = {got[W-2:0], sdata_o};
      if (!sdata_oe_o) oe_ok = 1'b0;
      if (b == 0) drdy_first = drdy_o;
      if (b > inj_at && inj_at >= 0 && drdy_o) drdy_seen = 1'b1;
      if (b == inj_at) begin word_i = inj_w; word_vld_i = 1'b1; end
    end
    frame_ni = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got, w;
    logic df, ok, ds;

    // R1, R2: every strobe combination at reset
    for (int k = 7; k >= 0; k--) begin
      do_reset(k[2], k[1], k[0]);
      @(negedge clk);
      check(ser_mode_o == 1'b0, "R1 first edge", ser_mode_o, 0);
      @(negedge clk);
      if (k == 0) check(ser_mode_o == 1'b1, "R1 second edge", ser_mode_o, 1);
      else begin
        check(ser_mode_o == 1'b0, "R2 locked out", ser_mode_o, 0);
        send_word(16'h5A5A);
        frame_ni = 1'b0;
        repeat (3) @(negedge clk);
        check(!drdy_o && !sclk_o && !sdata_oe_o, "R2 quiet", {drdy_o, sclk_o, sdata_oe_o}, 0);
        frame_ni = 1'b1;
      end
    end

    // R4: half-rate serial clock
    begin
      logic prev;
      @(negedge clk); prev = sclk_o;
      ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (sclk_o == prev) ok = 1'b0;
        prev = sclk_o;
      end
      check(ok, "R4 toggle", ok, 1);
    end

    // R5-R8: walking one then arithmetic patterns
    for (int i = 0; i < 32; i++) begin
      w = (i < 16) ? W'(1) << i : W'(i * 40503 + 4660);
      send_word(w);
      check(drdy_o == 1'b1, "R5 drdy set", drdy_o, 1);
      read_frame(-1, '0, got, df, ok, ds);
      check(got == w, "R6 frame bits", got, w);
      check(df == 1'b0, "R8 drdy cleared at start", df, 0);
      check(ok, "R7 oe during frame", ok, 1);
      #1 check(sdata_oe_o == 1'b0, "R7 oe off", sdata_oe_o, 0);
      repeat (2) @(negedge clk);
    end

    // R5: newest word before a frame wins
    send_word(16'h1111); send_word(16'h2222);
    read_frame(-1, '0, got, df, ok, ds);
    check(got == 16'h2222, "R5 replace", got, 16'h2222);
    repeat (2) @(negedge clk);

    // R8: no frame without drdy
    frame_ni = 1'b0; repeat (6) @(negedge clk);
    check(drdy_o == 1'b0, "R8 no data no frame", drdy_o, 0);
    frame_ni = 1'b1; @(negedge clk);

    // R9: word arriving mid-frame
    send_word(16'hC3A5);
    read_frame(4, 16'h3CE1, got, df, ok, ds);
    check(got == 16'hC3A5, "R9 frame intact", got, 16'hC3A5);
    check(ds == 1'b0, "R9 drdy held low", ds, 0);
    repeat (2) @(negedge clk);
    check(drdy_o == 1'b1, "R9 drdy after frame", drdy_o, 1);
    read_frame(-1, '0, got, df, ok, ds);
    check(got == 16'h3CE1, "R9 held word", got, 16'h3CE1);
    repeat (2) @(negedge clk);

    // R10: sync window
    send_word(16'hAAAA);
    @(negedge clk); sync_ni = 1'b0;
    @(negedge clk); sync_ni = 1'b1;
    @(negedge clk);
    check(drdy_o == 1'b0, "R10 drdy cleared", drdy_o, 1'b0);
    send_word(16'hBBBB);
    check(drdy_o == 1'b0, "R10 word dropped", drdy_o, 0);
    repeat (SYNC) @(negedge clk);
    send_word(16'h0F0F);
    check(drdy_o == 1'b1, "R10 drdy after window", drdy_o, 1);
    read_frame(-1, '0, got, df, ok, ds);
    check(got == 16'h0F0F, "R10 word after window", got, 16'h0F0F);
    repeat (2) @(negedge clk);

    // R11: calibration window
    send_word(16'h1234);
    @(negedge clk); cal_i = 1'b1;
    @(negedge clk); cal_i = 1'b0;
    check(drdy_o == 1'b0, "R11 drdy cleared", drdy_o, 0);
    send_word(16'h4321);
    repeat (SYNC) @(negedge clk);
    check(drdy_o == 1'b0, "R11 still in window", drdy_o, 0);
    repeat (CAL - SYNC) @(negedge clk);
    send_word(16'h9876);
    check(drdy_o == 1'b1, "R11 drdy after window", drdy_o, 1);
    read_frame(-1, '0, got, df, ok, ds);
    check(got == 16'h9876, "R11 word after window", got, 16'h9876);
    repeat (2) @(negedge clk);

    // R12: standby
    @(negedge clk); stby_i = 1'b1;
    send_word(16'hDEAD);
    check(drdy_o == 1'b0, "R12 no drdy in standby", drdy_o, 0);
    @(negedge clk); stby_i = 1'b0;
    repeat (2) @(negedge clk);
    check(drdy_o == 1'b0, "R12 word discarded", drdy_o, 0);
    send_word(16'hBEEF);
    read_frame(-1, '0, got, df, ok, ds);
    check(got == 16'hBEEF, "R12 post-standby word", got, 16'hBEEF);
    repeat (2) @(negedge clk);

    // R3: strobe raised in serial mode
    @(negedge clk); wr_ni = 1'b1;
    @(negedge clk);
    check(ser_mode_o == 1'b0, "R3 exit", ser_mode_o, 0);
    @(negedge clk);
    check(sclk_o == 1'b0, "R3 sclk stopped", sclk_o, 0);
    wr_ni = 1'b0;
    repeat (4) @(negedge clk);
    check(ser_mode_o == 1'b0, "R3 stays out", ser_mode_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule